// File: doc/BRIEF.md
# Indirect register bridge

The bridge gives a host a narrow window onto a wider remote 32-bit register space. The host sees four local registers. It puts a remote byte address in one of them and, for a store, the value in another. It then starts the transfer by writing a one-hot request into the command register. The bridge holds a request on a simple remote port until the far side answers or a programmable cycle budget runs out. It then captures any fetched word and raises a done flag in the command register. The host ends the exchange by writing zero to the command register, which returns it to all-zero and readies the bridge for the next transfer.

A remote side that never answers cannot hang the host. When the budget expires, the bridge completes the transfer anyway, flags the failure in the command register and, for a fetch, substitutes an all-ones word. The remote address is passed through unchanged; the remote space uses a 4-byte stride, and the bridge neither filters nor aligns the address.

Top module: `regwin_bridge`

## Requirements
- R1: Local word select is host_addr[3:2]: 0 command, 1 remote address, 2 fetched data, 3 store data. Address and store-data registers read back what was last written while no transfer is outstanding. Host writes to the fetched-data register have no effect. host_addr[1:0] is ignored.
- R2: Command bits: bit 0 = fetch, bit 1 = store, bit 2 = done, bit 3 = fault. With the bridge idle, a command write with bit 0 or bit 1 set raises rmt_req from the next cycle. rmt_we is low for a fetch, high for a store. rmt_addr and rmt_wdata carry the address and store-data registers.
- R3: rmt_req stays high, with rmt_addr, rmt_wdata and rmt_we unchanged, until the first cycle in which rmt_ack is high or the budget expires. It then falls on the next edge.
- R4: A cycle with rmt_req and rmt_ack high completes the transfer at the next edge. The done bit becomes 1 and the fault bit stays 0, so the command reads 0x5 after a fetch and 0x6 after a store. A fetch also captures rmt_rdata into the fetched-data register.
- R5: A command write with both bit 0 and bit 1 set starts a fetch only. The command then reads 0x1 and rmt_we stays low.
- R6: While a transfer is outstanding, host writes to the command, address and store-data registers are ignored. This includes a write that falls in the completion cycle.
- R7: While done is set, a command write with a nonzero value changes nothing. A write of zero returns the whole command register, fault included, to exactly 0.
- R8: If rmt_ack has not come by the end of the max(cfg_timeout,1)-th request cycle, the transfer completes with done and fault set. The command then reads 0xD for a fetch or 0xE for a store. A fetch loads 0xFFFFFFFF into the fetched-data register; a store leaves it unchanged. cfg_timeout is held steady while a transfer is outstanding.
- R9: If rmt_ack arrives in the last cycle of the budget, the transfer counts as answered, not timed out.
- R10: After reset, all four local registers read 0 and rmt_req is low.
- R11: With the bridge idle, a command write with neither bit 0 nor bit 1 set leaves the command register at 0 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 4 | Local byte offset; bits [3:2] select the word |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Selected local register, combinational from host_addr |
| cfg_timeout | input | 16 | Remote response budget in cycles (0 acts as 1) |
| rmt_req | output | 1 | Remote request, held until answered or timed out |
| rmt_we | output | 1 | Remote direction: 1 store, 0 fetch |
| rmt_addr | output | 32 | Remote byte address |
| rmt_wdata | output | 32 | Remote store value |
| rmt_ack | input | 1 | Remote answer, one cycle |
| rmt_rdata | input | 32 | Remote fetched value, valid with rmt_ack |

## Verification
Two events can fall on the same edge, and each collision is steered deliberately. In the first, a host register write meets the remote answer. The bench's responder is given a latency that makes its answer coincide with a host command-clear write. The run then requires the command to read the done code rather than zero. In the second, the remote answer meets the expiry of the budget. The latency is set to exactly one less than the budget, and the outcome must be a clean completion with the fetched word and no fault. A latency one cycle longer is used as the contrasting case, where the outcome must be a timeout.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // local window: byte offset width and word-select position
  localparam int unsigned LOC_AW   = 4;
  localparam int unsigned SEL_LSB  = 2;
  localparam int unsigned SEL_W    = LOC_AW - SEL_LSB;

  // word indices inside the window
  localparam logic [SEL_W-1:0] W_CMD  = 2'd0;
  localparam logic [SEL_W-1:0] W_ADDR = 2'd1;
  localparam logic [SEL_W-1:0] W_RDAT = 2'd2;
  localparam logic [SEL_W-1:0] W_WDAT = 2'd3;

  // command bit positions
  localparam int unsigned CB_RD  = 0;
  localparam int unsigned CB_WR  = 1;
  localparam int unsigned CB_ACK = 2;
  localparam int unsigned CB_ERR = 3;
  localparam int unsigned CMD_W  = 4;

  typedef struct packed {
    logic err;
    logic ack;
    logic wr;
    logic rd;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } rw_state_e;

endpackage

// File: rtl/regwin_timer.sv
module regwin_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  localparam logic [TW:0] ONE = {{TW{1'b0}}, 1'b1};

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;
  logic [TW:0]   lim_eff;
  logic [TW:0]   cnt_next_wide;

  // a zero budget behaves as a single cycle
  always_comb begin
    lim_eff       = (limit == '0) ? ONE : {1'b0, limit};
    cnt_next_wide = {1'b0, cnt_q} + ONE;
    expired       = run && (cnt_next_wide >= lim_eff);
  end

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    cnt_d  = run ? cnt_next_wide[TW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // the wait never outlasts the budget
  AST_TMO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt_q} < lim_eff)) else $error("timer beyond budget"); // R8

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_val,
  input  logic          rsp_ack,
  input  logic          tmo_hit,
  output logic          busy,
  output cmd_t          cmd,
  output logic          rd_take,
  output logic          rd_fault
);

  rw_state_e st_q, st_d;
  cmd_t      cmd_q, cmd_d;
  logic      cmd_en;
  logic      is_zero_wr;

  assign is_zero_wr = cmd_wr && (cmd_val == '0);

  // next-state and command contents
  always_comb begin
    st_d  = st_q;
    cmd_d = cmd_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_wr && cmd_val[CB_RD]) begin
          st_d  = ST_BUSY;
          cmd_d = '{err: 1'b0, ack: 1'b0, wr: 1'b0, rd: 1'b1};
        end else if (cmd_wr && cmd_val[CB_WR]) begin
          st_d  = ST_BUSY;
          cmd_d = '{err: 1'b0, ack: 1'b0, wr: 1'b1, rd: 1'b0};
        end
      end
      ST_BUSY: begin
        if (rsp_ack) begin
          st_d      = ST_DONE;
          cmd_d.ack = 1'b1;
        end else if (tmo_hit) begin
          st_d      = ST_DONE;
          cmd_d.ack = 1'b1;
          cmd_d.err = 1'b1;
        end
      end
      ST_DONE: begin
        if (is_zero_wr) begin
          st_d  = ST_IDLE;
          cmd_d = '0;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cmd_d = '0;
      end
    endcase
  end

  assign cmd_en = (cmd_d != cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  assign busy     = (st_q == ST_BUSY);
  assign cmd      = cmd_q;
  assign rd_take  = busy && cmd_q.rd && rsp_ack;
  assign rd_fault = busy && cmd_q.rd && !rsp_ack && tmo_hit;

  AST_RESP_SETS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_ack |=> cmd.ack && !cmd.err && !busy) else $error("answer not acknowledged"); // R4

  AST_TMO_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_ack && tmo_hit |=> cmd.ack && cmd.err && !busy) else $error("timeout not flagged"); // R8

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_ack && !tmo_hit |=> busy && $stable(cmd)) else $error("request dropped early"); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) && is_zero_wr |=> (cmd == '0)) else $error("clear left residue"); // R7

  AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.ack && !is_zero_wr |=> cmd.ack && $stable(cmd)) else $error("done state disturbed"); // R7

  AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.rd, cmd.wr})) else $error("two operations at once"); // R5

  AST_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.err |-> cmd.ack) else $error("fault without done"); // R8

  AST_IDLE_START_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && cmd_wr && cmd_val[CB_RD] |=> busy && cmd.rd && !cmd.wr) else $error("fetch priority lost"); // R5

endmodule

// File: rtl/regwin_regs.sv
module regwin_regs
  import regwin_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_wr,
  input  logic [SEL_W-1:0] hw_sel,
  input  logic [DW-1:0]    hw_data,
  input  logic             lock,
  input  logic             rd_take,
  input  logic             rd_fault,
  input  logic [DW-1:0]    rsp_data,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdat_q,
  output logic [DW-1:0]    rdat_q
);

  logic          addr_en;
  logic          wdat_en;
  logic          rdat_en;
  logic [DW-1:0] rdat_d;

  // host loads are blocked while a transfer is outstanding
  always_comb begin
    addr_en = hw_wr && !lock && (hw_sel == W_ADDR);
    wdat_en = hw_wr && !lock && (hw_sel == W_WDAT);
    rdat_en = rd_take || rd_fault;
    rdat_d  = rd_fault ? {DW{1'b1}} : rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= hw_data[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdat_q <= '0;
    end else if (wdat_en) begin
      wdat_q <= hw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (rdat_en) begin
      rdat_q <= rdat_d;
    end
  end

  AST_LOCKED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    lock && hw_wr |=> $stable(addr_q) && $stable(wdat_q)) else $error("host write leaked into a transfer"); // R6

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [LOC_AW-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [TW-1:0]     cfg_timeout,
  output logic              rmt_req,
  output logic              rmt_we,
  output logic [AW-1:0]     rmt_addr,
  output logic [DW-1:0]     rmt_wdata,
  input  logic              rmt_ack,
  input  logic [DW-1:0]     rmt_rdata
);

  logic [SEL_W-1:0] sel;
  logic             busy;
  cmd_t             cmd;
  logic             rd_take;
  logic             rd_fault;
  logic             tmo_hit;
  logic             cmd_wr;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdat_q;
  logic [DW-1:0]    rdat_q;
  logic [DW-1:0]    addr_view;
  logic [DW-1:0]    cmd_view;
  logic             unused_offset_bits;

  assign sel                = host_addr[SEL_LSB +: SEL_W];
  assign unused_offset_bits = ^host_addr[SEL_LSB-1:0];
  assign cmd_wr             = host_wr && (sel == W_CMD);

  regwin_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_val  (host_wdata),
    .rsp_ack  (rmt_ack),
    .tmo_hit  (tmo_hit),
    .busy     (busy),
    .cmd      (cmd),
    .rd_take  (rd_take),
    .rd_fault (rd_fault)
  );

  regwin_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .limit   (cfg_timeout),
    .expired (tmo_hit)
  );

  regwin_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_wr    (host_wr),
    .hw_sel   (sel),
    .hw_data  (host_wdata),
    .lock     (busy),
    .rd_take  (rd_take),
    .rd_fault (rd_fault),
    .rsp_data (rmt_rdata),
    .addr_q   (addr_q),
    .wdat_q   (wdat_q),
    .rdat_q   (rdat_q)
  );

  // widen the address register for the host view when it is narrower
  generate
    if (AW < DW) begin : g_addr_pad
      assign addr_view = {{(DW-AW){1'b0}}, addr_q};
    end else begin : g_addr_full
      assign addr_view = addr_q[DW-1:0];
    end
  endgenerate

  assign cmd_view = {{(DW-CMD_W){1'b0}}, cmd};

  always_comb begin
    unique case (sel)
      W_CMD:   host_rdata = cmd_view;
      W_ADDR:  host_rdata = addr_view;
      W_RDAT:  host_rdata = rdat_q;
      default: host_rdata = wdat_q;
    endcase
  end

  assign rmt_req   = busy;
  assign rmt_we    = busy && cmd.wr;
  assign rmt_addr  = addr_q;
  assign rmt_wdata = wdat_q;

  AST_REMOTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_req && !rmt_ack && !tmo_hit |=>
      rmt_req && $stable(rmt_addr) && $stable(rmt_wdata) && $stable(rmt_we)) else $error("remote request unstable"); // R3

  AST_RDATA_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_req && !rmt_we && !rmt_ack && tmo_hit |=> (host_rdata == {DW{1'b1}}) || (sel != W_RDAT)) else $error("fault word missing"); // R8

  AST_REQ_AFTER_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_req && rmt_ack |=> !rmt_req) else $error("request outlived answer"); // R3

endmodule

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;

  localparam int CLK_NS = 10;
  localparam logic [31:0] KEY = 32'h5A5A_0F0F;

  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic [3:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [15:0] cfg_timeout;
  logic        rmt_req;
  logic        rmt_we;
  logic [31:0] rmt_addr;
  logic [31:0] rmt_wdata;
  logic        rmt_ack;
  logic [31:0] rmt_rdata;

  int total = 0;
  int bad   = 0;
  int rsp_lat = -1;
  int rsp_cnt = 0;
  int req_len = 0;
  bit started = 0;

  // reference model state
  logic [3:0]  m_cmd;
  logic [31:0] m_addr, m_wd, m_rd;
  bit          m_busy;
  int          m_cnt;

  regwin_bridge u_regwin_bridge (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .cfg_timeout (cfg_timeout),
    .rmt_req     (rmt_req),
    .rmt_we      (rmt_we),
    .rmt_addr    (rmt_addr),
    .rmt_wdata   (rmt_wdata),
    .rmt_ack     (rmt_ack),
    .rmt_rdata   (rmt_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      2'd0:    return "R2 cmd";
      2'd1:    return "R1 addr";
      2'd2:    return "R4 rdata";
      default: return "R1 wdata";
    endcase
  endfunction

  function automatic logic [31:0] exp_view(input logic [1:0] s);
    case (s)
      2'd0:    return {28'd0, m_cmd};
      2'd1:    return m_addr;
      2'd2:    return m_rd;
      default: return m_wd;
    endcase
  endfunction

  // behavioural reference, one update per clock
  always @(posedge clk or negedge rst_n) begin
    int lim;
    if (!rst_n) begin
      m_cmd <= '0; m_addr <= '0; m_wd <= '0; m_rd <= '0; m_busy <= 0; m_cnt <= 0;
    end else begin
      lim = (cfg_timeout == 0) ? 1 : int'(cfg_timeout);
      if (m_busy) begin
        if (rmt_ack) begin
          if (m_cmd[0]) m_rd <= rmt_rdata;
          m_cmd <= m_cmd | 4'h4; m_busy <= 0; m_cnt <= 0;
        end else if (m_cnt + 1 >= lim) begin
          if (m_cmd[0]) m_rd <= 32'hFFFF_FFFF;
          m_cmd <= m_cmd | 4'hC; m_busy <= 0; m_cnt <= 0;
        end else begin
          m_cnt <= m_cnt + 1;
        end
      end else if (host_wr) begin
        case (host_addr[3:2])
          2'd0: begin
            if (m_cmd[2]) begin
              if (host_wdata == 0) m_cmd <= '0;
            end else if (host_wdata[0]) begin
              m_cmd <= 4'h1; m_busy <= 1;
            end else if (host_wdata[1]) begin
              m_cmd <= 4'h2; m_busy <= 1;
            end
          end
          2'd1: m_addr <= host_wdata;
          2'd3: m_wd <= host_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && started) begin
      chk(tag_of(host_addr[3:2]), host_rdata, exp_view(host_addr[3:2]));
      chk("R3 req", {31'd0, rmt_req}, {31'd0, m_busy});
      chk("R2 we", {31'd0, rmt_we}, {31'd0, m_busy && m_cmd[1]});
      chk("R3 raddr", rmt_addr, m_addr);
      chk("R3 rwdata", rmt_wdata, m_wd);
    end
  end

  // remote responder with selectable latency (-1 never answers)
  always @(negedge clk) begin
    if (rmt_req) begin
      req_len++;
      rmt_ack   <= (rsp_lat >= 0) && (rsp_cnt == rsp_lat);
      rmt_rdata <= rmt_addr ^ KEY;
      rsp_cnt++;
    end else begin
      rmt_ack <= 1'b0;
      rsp_cnt = 0;
    end
  end

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] v);
    host_addr = a; #1;
    v = host_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      peek(4'h0, v);
      if (v[2]) break;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    $display("FAIL R3 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    cfg_timeout = 16'd8; rmt_ack = 1'b0; rmt_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(posedge clk); #1;

    // R10 reset state
    for (int i = 0; i < 4; i++) begin
      peek(4'(i * 4), v); chk("R10 reset view", v, 32'd0);
    end
    chk("R10 req low", {31'd0, rmt_req}, 32'd0);

    // R1 map and readback, fetched-data register not writable
    hwrite(4'h4, 32'h1000_0010);
    hwrite(4'hC, 32'hCAFE_0001);
    hwrite(4'h8, 32'h0000_1234);
    peek(4'h5, v); chk("R1 addr readback", v, 32'h1000_0010);
    peek(4'hF, v); chk("R1 wdata readback", v, 32'hCAFE_0001);
    peek(4'h8, v); chk("R1 rdata write ignored", v, 32'd0);

    // R11 no op bits
    hwrite(4'h0, 32'h0000_000C);
    peek(4'h0, v); chk("R11 cmd stays zero", v, 32'd0);
    chk("R11 no request", {31'd0, rmt_req}, 32'd0);

    // R2 / R4 fetch
    rsp_lat = 2;
    hwrite(4'h0, 32'h1);
    chk("R2 fetch request", {31'd0, rmt_req}, 32'd1);
    chk("R2 fetch direction", {31'd0, rmt_we}, 32'd0);
    wait_done();
    peek(4'h0, v); chk("R4 fetch done code", v, 32'h5);
    peek(4'h8, v); chk("R4 fetched word", v, 32'h1000_0010 ^ KEY);

    // R7 nonzero write in done ignored, zero clears
    hwrite(4'h0, 32'h2);
    peek(4'h0, v); chk("R7 done kept", v, 32'h5);
    hwrite(4'h0, 32'h0);
    peek(4'h0, v); chk("R7 cleared", v, 32'h0);

    // R2 / R4 store
    rsp_lat = 0;
    hwrite(4'h0, 32'h2);
    chk("R2 store direction", {31'd0, rmt_we}, 32'd1);
    chk("R2 store data", rmt_wdata, 32'hCAFE_0001);
    wait_done();
    peek(4'h0, v); chk("R4 store done code", v, 32'h6);
    peek(4'h8, v); chk("R4 store keeps fetched word", v, 32'h1000_0010 ^ KEY);
    hwrite(4'h0, 32'h0);

    // R5 both bits, R6 writes while busy incl. completion cycle
    rsp_lat = 3;
    hwrite(4'h0, 32'h3);
    peek(4'h0, v); chk("R5 fetch wins", v, 32'h1);
    chk("R5 direction fetch", {31'd0, rmt_we}, 32'd0);
    hwrite(4'h4, 32'hDEAD_0000);
    hwrite(4'hC, 32'hBEEF_0000);
    hwrite(4'h0, 32'h0);
    hwrite(4'h0, 32'h0);
    peek(4'h0, v); chk("R6 clear in completion cycle dropped", v, 32'h5);
    peek(4'h4, v); chk("R6 addr unchanged", v, 32'h1000_0010);
    peek(4'hC, v); chk("R6 wdata unchanged", v, 32'hCAFE_0001);
    hwrite(4'h0, 32'h0);

    // R8 store timeout leaves fetched data
    cfg_timeout = 16'd4; rsp_lat = -1;
    hwrite(4'h0, 32'h2);
    wait_done();
    peek(4'h0, v); chk("R8 store timeout code", v, 32'hE);
    peek(4'h8, v); chk("R8 store timeout keeps data", v, 32'h1000_0010 ^ KEY);
    hwrite(4'h0, 32'h0);
    peek(4'h0, v); chk("R7 fault cleared", v, 32'h0);

    // R8 / R3 fetch timeout, request length equals budget
    req_len = 0;
    hwrite(4'h0, 32'h1);
    wait_done();
    peek(4'h0, v); chk("R8 fetch timeout code", v, 32'hD);
    peek(4'h8, v); chk("R8 all-ones word", v, 32'hFFFF_FFFF);
    chk("R3 request length", 32'(req_len), 32'd4);
    hwrite(4'h0, 32'h0);

    // R9 answer on the last budget cycle
    cfg_timeout = 16'd3; rsp_lat = 2;
    hwrite(4'h0, 32'h1);
    wait_done();
    peek(4'h0, v); chk("R9 answer wins tie", v, 32'h5);
    peek(4'h8, v); chk("R9 fetched word", v, 32'h1000_0010 ^ KEY);
    hwrite(4'h0, 32'h0);
    rsp_lat = 3;
    hwrite(4'h0, 32'h1);
    wait_done();
    peek(4'h0, v); chk("R9 one late is timeout", v, 32'hD);
    hwrite(4'h0, 32'h0);

    // R8 zero budget acts as one cycle
    cfg_timeout = 16'd0; rsp_lat = -1; req_len = 0;
    hwrite(4'h0, 32'h1);
    wait_done();
    peek(4'h0, v); chk("R8 zero budget code", v, 32'hD);
    chk("R8 zero budget length", 32'(req_len), 32'd1);
    hwrite(4'h0, 32'h0);

    // mixed traffic against the model
    for (int it = 0; it < 40; it++) begin
      cfg_timeout = 16'($urandom_range(1, 6));
      rsp_lat = int'($urandom_range(0, 7));
      hwrite(4'h4, {$urandom, 2'b00} >> 2 << 2);
      hwrite(4'hC, $urandom);
      hwrite(4'h0, 32'($urandom_range(1, 3)));
      for (int n = 0; n < 2; n++) begin
        case ($urandom_range(0, 3))
          0: hwrite(4'h0, 32'($urandom_range(1, 15)));
          1: hwrite(4'h4, $urandom);
          2: hwrite(4'h8, $urandom);
          default: hwrite(4'hC, $urandom);
        endcase
      end
      wait_done();
      hwrite(4'h0, 32'h0);
      peek(4'h0, v); chk("R7 cleared after traffic", v, 32'h0);
    end

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule